// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit performs the rotate-right operations of a 64-bit integer datapath. It takes the already-split fields of an instruction (the 6-bit function code, the 5-bit rs field and the 5-bit shift-amount field) together with the two operand values. It produces the destination value one clock later, qualified by a valid flag.

Two widths are supported. A word rotate acts on the low 32 bits of the operand and sign-extends its 32-bit result. A doubleword rotate acts on all 64 bits. The amount is taken from one of three places:

- the 5-bit immediate field;
- the immediate plus 32, which reaches doubleword amounts 32 to 63;
- the low bits of the rs operand value.

A rotate is told apart from the plain shift that shares its function code by the marker value 00001 in a field that the shift leaves unused. Any combination that is not one of the five rotate forms is flagged as illegal instead of producing a result.

Top module: `rot_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_illegal and out_data are all zero.
- R2: Function code 6'b000010 with rs_field 5'b00001 rotates rt_val[31:0] right by sa_field.
- R3: Function code 6'b000110 with sa_field 5'b00001 rotates rt_val[31:0] right by rs_val[4:0]. The upper bits of rs_val are ignored.
- R4: Function code 6'b111010 with rs_field 5'b00001 rotates all 64 bits of rt_val right by sa_field.
- R5: Function code 6'b111110 with rs_field 5'b00001 rotates all 64 bits of rt_val right by sa_field + 32, which covers amounts 32 to 63.
- R6: Function code 6'b010110 with sa_field 5'b00001 rotates all 64 bits of rt_val right by rs_val[5:0]. The upper bits of rs_val are ignored.
- R7: A word-rotate result fills out_data[63:32] with copies of result bit 31.
- R8: An effective amount of zero returns the operand unchanged. For a word rotate this is the sign-extended low half.
- R9: Any other function code, or a rotate function code whose marker field is not 5'b00001, gives out_illegal=1, out_valid=0 and out_data=0 one cycle later.
- R10: Results appear on the clock edge after the cycle in which in_valid is high. A cycle with in_valid low gives out_valid=0 and out_illegal=0 next cycle, and out_data keeps its value.
- R11: Operations issued on consecutive cycles each produce their own result, with no stall and no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| funct | input | 6 | Function code field |
| rs_field | input | 5 | rs register-number field (rotate marker for the immediate forms) |
| sa_field | input | 5 | Shift-amount field (rotate marker for the variable forms) |
| rs_val | input | 64 | Value of the rs operand (amount source for the variable forms) |
| rt_val | input | 64 | Value being rotated |
| out_valid | output | 1 | out_data holds a rotate result |
| out_illegal | output | 1 | The previous operation was not a rotate |
| out_data | output | 64 | Registered destination value |

## Verification
In every cycle the output register is delivering the result of the previous operation while the decoder classifies the next one. The bench therefore issues operations with no gaps between them. It mixes word and doubleword forms, legal and illegal codes, and occasional idle cycles, so that a result is always leaving the register while an unrelated decode is entering it. Each cycle's output is compared with a reference computed in the bench for the operation issued exactly one cycle earlier. Any result that is held too long or that leaks into the next cycle therefore fails the comparison. The random stimulus mostly supplies the correct marker but sometimes a wrong one, so that the legal-versus-illegal decision and the rotate datapath are both exercised in the same stream.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int unsigned XLEN    = 64;
    localparam int unsigned WLEN    = XLEN / 2;
    localparam int unsigned XAMT_W  = $clog2(XLEN);
    localparam int unsigned WAMT_W  = $clog2(WLEN);
    localparam int unsigned FUNCT_W = 6;
    localparam int unsigned FIELD_W = 5;

    localparam logic [FUNCT_W-1:0] FN_WROT_IMM = 6'b000010;
    localparam logic [FUNCT_W-1:0] FN_WROT_VAR = 6'b000110;
    localparam logic [FUNCT_W-1:0] FN_XROT_IMM = 6'b111010;
    localparam logic [FUNCT_W-1:0] FN_XROT_HI  = 6'b111110;
    localparam logic [FUNCT_W-1:0] FN_XROT_VAR = 6'b010110;

    localparam logic [FIELD_W-1:0] ROT_MARK = 5'b00001;

    typedef enum logic [1:0] {
        RW_NONE = 2'd0,
        RW_WORD = 2'd1,
        RW_DWORD = 2'd2
    } rot_width_e;

    typedef struct packed {
        rot_width_e         width;
        logic [XAMT_W-1:0]  amt;
    } rot_ctl_t;

    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    input  logic [FIELD_W-1:0] rs_field,
    input  logic [FIELD_W-1:0] sa_field,
    input  logic [XAMT_W-1:0]  rs_amt,
    output rot_ctl_t           ctl
);
    logic imm_mark;
    logic var_mark;

    assign imm_mark = (rs_field == ROT_MARK);
    assign var_mark = (sa_field == ROT_MARK);

    always_comb begin
        ctl.width = RW_NONE;
        ctl.amt   = '0;
        case (funct)
            FN_WROT_IMM: if (imm_mark) begin
                ctl.width = RW_WORD;
                ctl.amt   = {1'b0, sa_field};
            end
            FN_WROT_VAR: if (var_mark) begin
                ctl.width = RW_WORD;
                ctl.amt   = {1'b0, rs_amt[WAMT_W-1:0]};
            end
            FN_XROT_IMM: if (imm_mark) begin
                ctl.width = RW_DWORD;
                ctl.amt   = {1'b0, sa_field};
            end
            FN_XROT_HI: if (imm_mark) begin
                ctl.width = RW_DWORD;
                ctl.amt   = {1'b1, sa_field};
            end
            FN_XROT_VAR: if (var_mark) begin
                ctl.width = RW_DWORD;
                ctl.amt   = rs_amt;
            end
            default: begin
                ctl.width = RW_NONE;
                ctl.amt   = '0;
            end
        endcase
    end

    // r9: a code outside the rotate set never decodes as a rotate
    always_comb begin
        if (funct != FN_WROT_IMM && funct != FN_WROT_VAR && funct != FN_XROT_IMM &&
            funct != FN_XROT_HI && funct != FN_XROT_VAR)
            p_unknown_funct_r9: assert (ctl.width == RW_NONE);
    end

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int unsigned W = 64,
    localparam int unsigned LG = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LG-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [LG:0][W-1:0] stage;

    assign stage[0] = din;

    for (genvar g = 0; g < LG; g++) begin : g_stage
        localparam int unsigned SH = 1 << g;
        assign stage[g+1] = amt[g] ? {stage[g][SH-1:0], stage[g][W-1:SH]} : stage[g];
    end

    assign dout = stage[LG];

    // r8: zero amount passes the operand through all stages untouched
    always_comb begin
        if (amt == '0)
            p_zero_amount_r8: assert (dout == din);
    end

endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [5:0]         funct,
    input  logic [4:0]         rs_field,
    input  logic [4:0]         sa_field,
    input  logic [63:0]        rs_val,
    input  logic [63:0]        rt_val,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [63:0]        out_data
);
    rot_ctl_t           ctl;
    logic [WLEN-1:0]    word_res;
    logic [XLEN-1:0]    dword_res;
    logic [XLEN-1:0]    next_data;
    logic               r_word;

    rot_decode u_dec (
        .funct    (funct),
        .rs_field (rs_field),
        .sa_field (sa_field),
        .rs_amt   (rs_val[XAMT_W-1:0]),
        .ctl      (ctl)
    );

    rot_barrel #(.W(WLEN)) u_word (
        .din  (rt_val[WLEN-1:0]),
        .amt  (ctl.amt[WAMT_W-1:0]),
        .dout (word_res)
    );

    rot_barrel #(.W(XLEN)) u_dword (
        .din  (rt_val),
        .amt  (ctl.amt),
        .dout (dword_res)
    );

    always_comb begin
        case (ctl.width)
            RW_WORD:  next_data = sext_word(word_res);
            RW_DWORD: next_data = dword_res;
            default:  next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_data    <= '0;
            r_word      <= 1'b0;
        end else begin
            out_valid   <= in_valid && (ctl.width != RW_NONE);
            out_illegal <= in_valid && (ctl.width == RW_NONE);
            if (in_valid) begin
                out_data <= next_data;
                r_word   <= (ctl.width == RW_WORD);
            end
        end
    end

    // R9: valid and illegal are never raised together
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_illegal}));

    // R10: a legal operation yields a valid result on the next edge
    p_legal_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.width != RW_NONE) |=> out_valid);

    // R9: an illegal operation raises the flag with a zero result
    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.width == RW_NONE) |=> (out_illegal && out_data == '0));

    // R10: an idle cycle clears the flags and holds the data
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_data)));

    // R7: a word result is sign-extended from bit 31
    p_word_sext_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_word) |-> (out_data[XLEN-1:WLEN] == {(XLEN-WLEN){out_data[WLEN-1]}}));

endmodule

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  funct;
    logic [4:0]  rs_field;
    logic [4:0]  sa_field;
    logic [63:0] rs_val;
    logic [63:0] rt_val;
    logic        out_valid;
    logic        out_illegal;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit          pend = 0;
    bit          e_valid, e_illegal;
    logic [63:0] e_data = '0;
    string       e_req;

    always #4 clk = ~clk;

    rot_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .funct(funct),
        .rs_field(rs_field), .sa_field(sa_field), .rs_val(rs_val), .rt_val(rt_val),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
    );

    function automatic logic [63:0] ref_word(input logic [63:0] x, input int a);
        logic [31:0] y;
        y = x[31:0];
        if (a != 0) y = (y >> a) | (y << (32 - a));
        return {{32{y[31]}}, y};
    endfunction

    function automatic logic [63:0] ref_dword(input logic [63:0] x, input int a);
        logic [63:0] y;
        y = x;
        if (a != 0) y = (y >> a) | (y << (64 - a));
        return y;
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== e_valid || out_illegal !== e_illegal || out_data !== e_data) begin
            errors++;
            $display("FAIL %s: got v=%0b i=%0b d=%h, expected v=%0b i=%0b d=%h",
                     e_req, out_valid, out_illegal, out_data, e_valid, e_illegal, e_data);
        end
    endtask

    task automatic issue(input bit v, input logic [5:0] f, input logic [4:0] rsf,
                         input logic [4:0] saf, input logic [63:0] rsv, input logic [63:0] rtv);
        @(negedge clk);
        if (pend) check_out();
        in_valid = v; funct = f; rs_field = rsf; sa_field = saf; rs_val = rsv; rt_val = rtv;
        pend = 1;
        if (!v) begin
            e_valid = 0; e_illegal = 0; e_req = "R10 idle hold R11";
        end else begin
            e_valid = 1; e_illegal = 0;
            if (f == 6'b000010 && rsf == 5'b00001) begin
                e_data = ref_word(rtv, int'(saf)); e_req = "R2 R7 R8 R11";
            end else if (f == 6'b000110 && saf == 5'b00001) begin
                e_data = ref_word(rtv, int'(rsv[4:0])); e_req = "R3 R7 R8 R11";
            end else if (f == 6'b111010 && rsf == 5'b00001) begin
                e_data = ref_dword(rtv, int'(saf)); e_req = "R4 R8 R11";
            end else if (f == 6'b111110 && rsf == 5'b00001) begin
                e_data = ref_dword(rtv, int'(saf) + 32); e_req = "R5 R11";
            end else if (f == 6'b010110 && saf == 5'b00001) begin
                e_data = ref_dword(rtv, int'(rsv[5:0])); e_req = "R6 R8 R11";
            end else begin
                e_valid = 0; e_illegal = 1; e_data = '0; e_req = "R9 illegal";
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] fl [5];
        fl[0] = 6'b000010; fl[1] = 6'b000110; fl[2] = 6'b111010;
        fl[3] = 6'b111110; fl[4] = 6'b010110;
        void'($urandom(32'd1234));
        rst = 1; in_valid = 0; funct = 0; rs_field = 0; sa_field = 0; rs_val = 0; rt_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_valid = 0; e_illegal = 0; e_data = '0; e_req = "R1 reset";
        check_out();
        rst = 0;
        @(negedge clk);
        check_out();

        // directed corners
        issue(1, 6'b000010, 5'b00001, 5'd0,  64'h0, 64'h1234_5678_8765_4321); // R8 word zero, R7 sext
        issue(1, 6'b000010, 5'b00001, 5'd4,  64'h0, 64'hFFFF_0000_0000_000F);
        issue(1, 6'b000110, 5'b00001, 5'b00001, 64'hFFFF_FFFF_FFFF_FFE1, 64'h0000_0000_0000_0001); // R3 upper rs ignored
        issue(1, 6'b111010, 5'b00001, 5'd0,  64'h0, 64'hDEAD_BEEF_0123_4567); // R8 dword zero
        issue(1, 6'b111110, 5'b00001, 5'd0,  64'h0, 64'hDEAD_BEEF_0123_4567); // R5 amount 32
        issue(1, 6'b111110, 5'b00001, 5'd31, 64'h0, 64'h8000_0000_0000_0001); // R5 amount 63
        issue(1, 6'b010110, 5'b00001, 5'b00001, 64'hFFFF_FFFF_FFFF_FFC0, 64'hCAFE_F00D_1111_2222); // R6 zero
        issue(1, 6'b010110, 5'b00001, 5'b00001, 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001); // R6 63
        issue(0, 6'b000010, 5'b00001, 5'd3,  64'h0, 64'h5); // R10 idle
        issue(1, 6'b000000, 5'b00001, 5'd3,  64'h0, 64'h5); // R9 plain shift code
        issue(1, 6'b000010, 5'b00000, 5'd3,  64'h0, 64'h5); // R9 wrong marker
        issue(1, 6'b010110, 5'b00001, 5'b00010, 64'h3, 64'h5); // R9 wrong marker
        issue(0, 6'b000000, 5'b00000, 5'd0,  64'h0, 64'h0); // R10 hold zero

        for (int i = 0; i < 400; i++) begin
            int k;
            logic [5:0] f;
            logic [4:0] rsf, saf;
            k = int'($urandom_range(0, 9));
            f = (k < 5) ? fl[k] : ((k < 7) ? fl[$urandom_range(0, 4)] : 6'($urandom));
            rsf = 5'($urandom); saf = 5'($urandom);
            if ($urandom_range(0, 7) != 0) begin
                if (f == 6'b000110 || f == 6'b010110) saf = 5'b00001;
                else rsf = 5'b00001;
            end
            issue($urandom_range(0, 9) != 0, f, rsf, saf,
                  {$urandom, $urandom}, {$urandom, $urandom});
        end
        issue(0, 6'b000000, 5'b00000, 5'd0, 64'h0, 64'h0);
        @(negedge clk);
        check_out();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule